// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block brings one switchable power domain up or down through a fixed series of steps, one control change per clock cycle. A power-up pulse closes a primary and then a secondary power switch, waits for two power-good acknowledges, then ungates the clock, drops isolation, releases the domain reset and wakes the domain's SRAM banks. If a bus fence is configured, power-up ends by lowering the fence. Power-down runs the same steps mirrored: it raises the fence first, then puts the SRAM to sleep, isolates, resets, gates the clock and opens both switches.

Every handshake wait is bounded by a cycle counter. If an acknowledge does not arrive in time, the sequence stops where it is and reports an error. The controls keep their current values until software issues a new request. The block flags `busy` while a sequence runs and pulses `done` or `err` when it finishes.

Top module: `pd_sequencer`

## Requirements
- R1: After synchronous reset the domain is off: `iso_o`=1, `rst_n_o`=0, `clk_off_o`=1, `sw_main_o`=0, `sw_aux_o`=0, every `sram_pd_o` bit 1, `fence_req_o`=1 only when `FENCE_MASK` is non-zero, and `done_o`, `err_o`, `busy_o` are 0.
- R2: Power-up sets `sw_main_o`, then `sw_aux_o` on the next cycle. It then waits until `pg_main_i` and `pg_aux_i` are both 1. After that it clears `clk_off_o`, clears `iso_o`, raises `rst_n_o` and clears all `sram_pd_o` bits, each on its own successive cycle.
- R3: After waking the SRAM, power-up waits until every `sram_ack_i` bit selected by `SRAM_ACK_MASK` reads 0. Unselected bits are ignored. With an all-zero mask and no fence, `done_o` rises on the ninth clock edge, counting the edge that samples the request.
- R4: With a non-zero `FENCE_MASK`, power-up ends by lowering `fence_req_o`. It then waits until every `fence_ack_i` bit selected by the mask reads 0. Unselected bits are ignored.
- R5: With a non-zero `FENCE_MASK`, power-down starts by raising `fence_req_o`. It waits until every selected `fence_ack_i` bit reads 1 before anything else changes.
- R6: Power-down then sets all `sram_pd_o` bits and waits for every selected `sram_ack_i` bit to read 1. It then sets `iso_o`, lowers `rst_n_o`, sets `clk_off_o`, clears `sw_main_o` and clears `sw_aux_o`, each on its own successive cycle.
- R7: Power-down completes once both power-good inputs read 0. Every successful sequence ends with `done_o` high for exactly one cycle.
- R8: If a wait has not been satisfied by its `TIMEOUT`-th cycle, `err_o` pulses for one cycle, `busy_o` drops and all controls hold their values. After such an abort, either request runs its full sequence.
- R9: A request that arrives while `busy_o` is 1 is ignored.
- R10: A request for the state the domain is already in produces a one-cycle `done_o` on the next cycle and changes no control output.
- R11: When the block is idle and both requests are high, the power-down request wins.
- R12: `busy_o` is 1 from the cycle after a request is accepted until the cycle in which `done_o` or `err_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_up_i | input | 1 | Power-up request |
| req_down_i | input | 1 | Power-down request |
| pg_main_i | input | 1 | Power-good acknowledge of the primary switch |
| pg_aux_i | input | 1 | Power-good acknowledge of the secondary switch |
| sram_ack_i | input | ACK_W | SRAM sleep acknowledges |
| fence_ack_i | input | FENCE_W | Bus fence status |
| sw_main_o | output | 1 | Primary power switch enable |
| sw_aux_o | output | 1 | Secondary power switch enable |
| clk_off_o | output | 1 | Domain clock gate (1 = gated) |
| iso_o | output | 1 | Domain output isolation |
| rst_n_o | output | 1 | Domain reset, active low |
| sram_pd_o | output | SRAM_W | SRAM power-down controls |
| fence_req_o | output | 1 | Bus fence request |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| busy_o | output | 1 | A sequence is running |
| err_o | output | 1 | One-cycle pulse when a wait times out |

## Verification
The bench builds two copies of the block. The first uses a 4-bit SRAM acknowledge mask with one bit left unselected, a 4-bit fence with two bits selected and `TIMEOUT`=16. This makes every wait state reachable, lets the bench drive the unselected bits against the selected ones, and keeps a full timeout window short enough to count exactly. The second copy has both masks zero, so the skip paths are taken, and its power-good inputs follow its switches directly, so both full sequences have a fixed, exact latency.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_U_SW1, ST_U_SW2, ST_U_PG, ST_U_CLK, ST_U_ISO, ST_U_RST,
    ST_U_SRAM, ST_U_SRAMW, ST_U_FENCE, ST_U_FENCEW, ST_FIN_UP,
    ST_D_FENCE, ST_D_FENCEW, ST_D_SRAM, ST_D_SRAMW, ST_D_ISO,
    ST_D_RST, ST_D_CLK, ST_D_SW1, ST_D_SW2, ST_D_PG, ST_FIN_DOWN
  } seq_state_e;

  typedef enum logic [1:0] {
    DOM_OFF,
    DOM_ON,
    DOM_UNKNOWN
  } dom_state_e;

  function automatic logic is_wait_state(seq_state_e s);
    return (s == ST_U_PG) || (s == ST_U_SRAMW) || (s == ST_U_FENCEW) ||
           (s == ST_D_FENCEW) || (s == ST_D_SRAMW) || (s == ST_D_PG);
  endfunction

endpackage

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic waiting,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  // Reloads whenever the sequencer is outside a wait state, so each
  // wait starts with a full window.
  always_ff @(posedge clk) begin
    if (rst || !waiting) begin
      cnt_q <= RELOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = waiting && (cnt_q == '0);
endmodule

// File: rtl/pd_ack_eval.sv
module pd_ack_eval #(
  parameter int ACK_W = 4,
  parameter logic [ACK_W-1:0] SRAM_ACK_MASK = '1,
  parameter int FENCE_W = 4,
  parameter logic [FENCE_W-1:0] FENCE_MASK = '1
) (
  input  logic               pg_main_i,
  input  logic               pg_aux_i,
  input  logic [ACK_W-1:0]   sram_ack_i,
  input  logic [FENCE_W-1:0] fence_ack_i,
  output logic               pg_up,
  output logic               pg_down,
  output logic               sram_awake,
  output logic               sram_asleep,
  output logic               fence_open,
  output logic               fence_closed
);
  logic [ACK_W-1:0]   sram_sel;
  logic [FENCE_W-1:0] fence_sel;

  assign sram_sel  = sram_ack_i & SRAM_ACK_MASK;
  assign fence_sel = fence_ack_i & FENCE_MASK;

  assign pg_up        = pg_main_i & pg_aux_i;
  assign pg_down      = ~pg_main_i & ~pg_aux_i;
  assign sram_awake   = (sram_sel == '0);
  assign sram_asleep  = (sram_sel == SRAM_ACK_MASK);
  assign fence_open   = (fence_sel == '0);
  assign fence_closed = (fence_sel == FENCE_MASK);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int SRAM_W = 4,
  parameter int ACK_W = 4,
  parameter logic [ACK_W-1:0] SRAM_ACK_MASK = '1,
  parameter int FENCE_W = 4,
  parameter logic [FENCE_W-1:0] FENCE_MASK = '1,
  parameter int TIMEOUT = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_up_i,
  input  logic               req_down_i,
  input  logic               pg_main_i,
  input  logic               pg_aux_i,
  input  logic [ACK_W-1:0]   sram_ack_i,
  input  logic [FENCE_W-1:0] fence_ack_i,
  output logic               sw_main_o,
  output logic               sw_aux_o,
  output logic               clk_off_o,
  output logic               iso_o,
  output logic               rst_n_o,
  output logic [SRAM_W-1:0]  sram_pd_o,
  output logic               fence_req_o,
  output logic               done_o,
  output logic               busy_o,
  output logic               err_o
);
  localparam logic HAS_FENCE = (FENCE_MASK != '0);
  localparam logic HAS_SACK  = (SRAM_ACK_MASK != '0);

  seq_state_e state_q;
  dom_state_e dom_q;
  logic waiting, expired, wait_ok;
  logic pg_up, pg_down, sram_awake, sram_asleep, fence_open, fence_closed;

  pd_ack_eval #(
    .ACK_W(ACK_W), .SRAM_ACK_MASK(SRAM_ACK_MASK),
    .FENCE_W(FENCE_W), .FENCE_MASK(FENCE_MASK)
  ) u_ack (
    .pg_main_i(pg_main_i), .pg_aux_i(pg_aux_i),
    .sram_ack_i(sram_ack_i), .fence_ack_i(fence_ack_i),
    .pg_up(pg_up), .pg_down(pg_down),
    .sram_awake(sram_awake), .sram_asleep(sram_asleep),
    .fence_open(fence_open), .fence_closed(fence_closed)
  );

  assign waiting = is_wait_state(state_q);

  pd_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .waiting(waiting), .expired(expired)
  );

  always_comb begin
    case (state_q)
      ST_U_PG:     wait_ok = pg_up;
      ST_U_SRAMW:  wait_ok = sram_awake;
      ST_U_FENCEW: wait_ok = fence_open;
      ST_D_FENCEW: wait_ok = fence_closed;
      ST_D_SRAMW:  wait_ok = sram_asleep;
      ST_D_PG:     wait_ok = pg_down;
      default:     wait_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      dom_q       <= DOM_OFF;
      sw_main_o   <= 1'b0;
      sw_aux_o    <= 1'b0;
      clk_off_o   <= 1'b1;
      iso_o       <= 1'b1;
      rst_n_o     <= 1'b0;
      sram_pd_o   <= '1;
      fence_req_o <= HAS_FENCE;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (waiting && !wait_ok && expired) begin
        // Abort: controls stay where they are, domain state becomes unknown.
        err_o   <= 1'b1;
        dom_q   <= DOM_UNKNOWN;
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (req_down_i) begin
              if (dom_q == DOM_OFF) done_o <= 1'b1;
              else state_q <= HAS_FENCE ? ST_D_FENCE : ST_D_SRAM;
            end else if (req_up_i) begin
              if (dom_q == DOM_ON) done_o <= 1'b1;
              else state_q <= ST_U_SW1;
            end
          end
          ST_U_SW1: begin sw_main_o <= 1'b1; state_q <= ST_U_SW2; end
          ST_U_SW2: begin sw_aux_o  <= 1'b1; state_q <= ST_U_PG;  end
          ST_U_PG:  if (wait_ok) state_q <= ST_U_CLK;
          ST_U_CLK: begin clk_off_o <= 1'b0; state_q <= ST_U_ISO; end
          ST_U_ISO: begin iso_o     <= 1'b0; state_q <= ST_U_RST; end
          ST_U_RST: begin rst_n_o   <= 1'b1; state_q <= ST_U_SRAM; end
          ST_U_SRAM: begin
            sram_pd_o <= '0;
            state_q   <= HAS_SACK ? ST_U_SRAMW : (HAS_FENCE ? ST_U_FENCE : ST_FIN_UP);
          end
          ST_U_SRAMW: if (wait_ok) state_q <= HAS_FENCE ? ST_U_FENCE : ST_FIN_UP;
          ST_U_FENCE: begin fence_req_o <= 1'b0; state_q <= ST_U_FENCEW; end
          ST_U_FENCEW: if (wait_ok) state_q <= ST_FIN_UP;
          ST_FIN_UP: begin
            done_o  <= 1'b1;
            dom_q   <= DOM_ON;
            state_q <= ST_IDLE;
          end
          ST_D_FENCE: begin fence_req_o <= 1'b1; state_q <= ST_D_FENCEW; end
          ST_D_FENCEW: if (wait_ok) state_q <= ST_D_SRAM;
          ST_D_SRAM: begin
            sram_pd_o <= '1;
            state_q   <= HAS_SACK ? ST_D_SRAMW : ST_D_ISO;
          end
          ST_D_SRAMW: if (wait_ok) state_q <= ST_D_ISO;
          ST_D_ISO: begin iso_o     <= 1'b1; state_q <= ST_D_RST; end
          ST_D_RST: begin rst_n_o   <= 1'b0; state_q <= ST_D_CLK; end
          ST_D_CLK: begin clk_off_o <= 1'b1; state_q <= ST_D_SW1; end
          ST_D_SW1: begin sw_main_o <= 1'b0; state_q <= ST_D_SW2; end
          ST_D_SW2: begin sw_aux_o  <= 1'b0; state_q <= ST_D_PG;  end
          ST_D_PG:  if (wait_ok) state_q <= ST_FIN_DOWN;
          ST_FIN_DOWN: begin
            done_o  <= 1'b1;
            dom_q   <= DOM_OFF;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter int SRAM_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_main_o,
  input logic              sw_aux_o,
  input logic              clk_off_o,
  input logic              iso_o,
  input logic              rst_n_o,
  input logic [SRAM_W-1:0] sram_pd_o,
  input logic              done_o,
  input logic              busy_o,
  input logic              err_o
);
  // R2: the clock runs only with both switches closed
  p_clk_needs_power_r2: assert property (@(posedge clk) disable iff (rst)
    !clk_off_o |-> (sw_main_o && sw_aux_o));

  // R6: reset is asserted only behind isolation
  p_iso_before_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_o) |-> iso_o);

  // R6: reset is released only while the clock runs
  p_reset_with_clock_r6: assert property (@(posedge clk) disable iff (rst)
    rst_n_o |-> !clk_off_o);

  // R3: SRAM is awake only while the domain is out of reset
  p_sram_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    (sram_pd_o != {SRAM_W{1'b1}}) |-> rst_n_o);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: error and done never coincide, and an error ends the sequence
  p_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));
  p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o);

  // R12: busy has dropped when done appears
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind pd_sequencer pd_sequencer_chk #(.SRAM_W(SRAM_W)) u_chk (
  .clk(clk), .rst(rst), .sw_main_o(sw_main_o), .sw_aux_o(sw_aux_o),
  .clk_off_o(clk_off_o), .iso_o(iso_o), .rst_n_o(rst_n_o),
  .sram_pd_o(sram_pd_o), .done_o(done_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/test_pd_sequencer.sv
`timescale 1ns/1ps
module test_pd_sequencer;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  // main instance
  logic req_up = 1'b0, req_down = 1'b0;
  logic pg_main, pg_aux;
  logic [3:0] sram_ack, fence_ack;
  logic sw_main, sw_aux, clk_off, iso, rst_n, fence_req, done, busy, err;
  logic [3:0] sram_pd;

  pd_sequencer #(
    .SRAM_W(4), .ACK_W(4), .SRAM_ACK_MASK(4'b0111),
    .FENCE_W(4), .FENCE_MASK(4'b0110), .TIMEOUT(TMO)
  ) i_pd_sequencer (
    .clk(clk), .rst(rst), .req_up_i(req_up), .req_down_i(req_down),
    .pg_main_i(pg_main), .pg_aux_i(pg_aux), .sram_ack_i(sram_ack),
    .fence_ack_i(fence_ack), .sw_main_o(sw_main), .sw_aux_o(sw_aux),
    .clk_off_o(clk_off), .iso_o(iso), .rst_n_o(rst_n), .sram_pd_o(sram_pd),
    .fence_req_o(fence_req), .done_o(done), .busy_o(busy), .err_o(err)
  );

  // bare instance: no SRAM acknowledge, no fence
  logic b_req_up = 1'b0, b_req_down = 1'b0;
  logic b_sw_main, b_sw_aux, b_clk_off, b_iso, b_rst_n, b_fence, b_done, b_busy, b_err;
  logic [3:0] b_sram_pd;

  pd_sequencer #(
    .SRAM_W(4), .ACK_W(4), .SRAM_ACK_MASK(4'b0000),
    .FENCE_W(4), .FENCE_MASK(4'b0000), .TIMEOUT(TMO)
  ) i_pd_sequencer_bare (
    .clk(clk), .rst(rst), .req_up_i(b_req_up), .req_down_i(b_req_down),
    .pg_main_i(b_sw_main), .pg_aux_i(b_sw_aux), .sram_ack_i(4'hF),
    .fence_ack_i(4'h0), .sw_main_o(b_sw_main), .sw_aux_o(b_sw_aux),
    .clk_off_o(b_clk_off), .iso_o(b_iso), .rst_n_o(b_rst_n), .sram_pd_o(b_sram_pd),
    .fence_req_o(b_fence), .done_o(b_done), .busy_o(b_busy), .err_o(b_err)
  );

  // domain responder for the main instance
  logic stall_pg = 1'b0, stall_fence = 1'b0;
  logic [1:0] sw_d1, sw_d2;
  logic [3:0] sram_d;
  logic fence_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_d1 <= '0; sw_d2 <= '0; sram_d <= 4'hF; fence_d <= 1'b1;
    end else begin
      sw_d1 <= {sw_main, sw_aux}; sw_d2 <= sw_d1; sram_d <= sram_pd; fence_d <= fence_req;
    end
  end
  assign pg_main   = sw_d2[1] & ~stall_pg;
  assign pg_aux    = sw_d2[0] & ~stall_pg;
  // bit 3 is unselected and always disagrees with its request
  assign sram_ack  = {~sram_pd[3], sram_d[2:0]};
  // bits 0 and 3 are unselected and disagree with the fence request
  assign fence_ack = {~fence_d, {2{fence_d & ~stall_fence}}, ~fence_d};

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard: {done, err, sw_main, sw_aux, clk_off, iso, rst_n, sram_pd[3:0], fence}
  logic [11:0] exp_q[$];
  string tag_q[$];
  logic [11:0] last_exp, last_obs;
  bit mon_en = 1'b0;
  string cur_tag = "R1";
  logic m_done = 0, m_err = 0, m_sw1 = 0, m_sw2 = 0, m_clk = 1, m_iso = 1, m_rstn = 0, m_fence = 1;
  logic [3:0] m_sram = 4'hF;
  int m_dom = 0; // 0 off, 1 on, 2 unknown

  function automatic logic [11:0] obs_snap();
    return {done, err, sw_main, sw_aux, clk_off, iso, rst_n, sram_pd, fence_req};
  endfunction

  task automatic emit();
    logic [11:0] s;
    s = {m_done, m_err, m_sw1, m_sw2, m_clk, m_iso, m_rstn, m_sram, m_fence};
    if (s != last_exp) begin
      exp_q.push_back(s);
      tag_q.push_back(cur_tag);
      last_exp = s;
    end
  endtask

  task automatic pulse_done();
    m_done = 1; emit(); m_done = 0; emit();
  endtask

  task automatic pulse_err();
    m_err = 1; emit(); m_err = 0; emit(); m_dom = 2;
  endtask

  task automatic model_up();
    if (m_dom == 1) pulse_done();
    else begin
      m_sw1 = 1; emit(); m_sw2 = 1; emit(); m_clk = 0; emit(); m_iso = 0; emit();
      m_rstn = 1; emit(); m_sram = 4'h0; emit(); m_fence = 0; emit(); pulse_done();
    end
    m_dom = 1;
  endtask

  task automatic model_down();
    if (m_dom == 0) pulse_done();
    else begin
      m_fence = 1; emit(); m_sram = 4'hF; emit(); m_iso = 1; emit(); m_rstn = 0; emit();
      m_clk = 1; emit(); m_sw1 = 0; emit(); m_sw2 = 0; emit(); pulse_done();
    end
    m_dom = 0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [11:0] cur;
      cur = obs_snap();
      if (cur != last_obs) begin
        if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected change"}, 32'(cur), 32'(last_obs));
        else begin
          logic [11:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cur == e, t, 32'(cur), 32'(e));
        end
        last_obs = cur;
      end
    end
  end

  task automatic request(input bit up, input bit down, input bit expect_busy);
    @(negedge clk); req_up = up; req_down = down;
    @(negedge clk); req_up = 1'b0; req_down = 1'b0;
    if (expect_busy) chk(busy == 1'b1, "R12 busy after accept", 32'(busy), 1);
  endtask

  task automatic wait_end(input string tag);
    int n = 0;
    while (!(done || err) && n < 300) begin @(negedge clk); n++; end
    chk(n < 300, {tag, " completion"}, 32'(n), 300);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " all steps seen"}, 32'(exp_q.size()), 0);
  endtask

  task automatic bare_latency(input bit up, input string tag);
    int n;
    @(negedge clk); b_req_up = up; b_req_down = ~up;
    @(negedge clk); b_req_up = 1'b0; b_req_down = 1'b0;
    n = 1;
    while (!b_done && !b_err && n < 100) begin @(negedge clk); n++; end
    chk(n == 9 && b_done, tag, 32'(n), 9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(obs_snap() == 12'b00_00_1_1_0_1111_1, "R1 reset controls", 32'(obs_snap()), 12'h0DF);
    chk({busy, b_busy, b_done, b_err} == 4'b0, "R1 status idle", 32'({busy, b_busy, b_done, b_err}), 0);
    chk({b_fence, b_iso, b_clk_off, b_rst_n} == 4'b0110, "R1 bare fence low",
        32'({b_fence, b_iso, b_clk_off, b_rst_n}), 4'b0110);
    last_obs = obs_snap();
    last_exp = last_obs;
    mon_en = 1'b1;

    // R2 R3 R4: full power-up with masked acknowledges
    cur_tag = "R2 R3 R4 power-up order";
    model_up(); request(1, 0, 1); wait_end(cur_tag);

    // R10: already on
    cur_tag = "R10 up while on";
    model_up(); request(1, 0, 0); wait_end(cur_tag);

    // R5 R6 R7 R9: power-down with a stray request mid-sequence
    cur_tag = "R5 R6 R7 R9 power-down order";
    model_down(); request(0, 1, 1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R9 busy mid-sequence", 32'(busy), 1);
    req_up = 1'b1; @(negedge clk); req_up = 1'b0;
    wait_end(cur_tag);

    // R10: already off
    cur_tag = "R10 down while off";
    model_down(); request(0, 1, 0); wait_end(cur_tag);

    // R11: both requests while on -> power-down
    cur_tag = "R2 up before R11";
    model_up(); request(1, 0, 1); wait_end(cur_tag);
    cur_tag = "R11 down wins";
    model_down(); request(1, 1, 1); wait_end(cur_tag);

    // R8: power-good never arrives
    begin
      int n;
      cur_tag = "R8 power-good timeout";
      stall_pg = 1'b1;
      m_sw1 = 1; emit(); m_sw2 = 1; emit(); pulse_err();
      @(negedge clk); req_up = 1'b1; @(negedge clk); req_up = 1'b0;
      while (!sw_aux) @(negedge clk);
      n = 0;
      while (!err && n < 100) begin @(negedge clk); n++; end
      chk(n == TMO, "R8 timeout window", 32'(n), 32'(TMO));
      repeat (4) @(negedge clk);
      chk({sw_main, clk_off, busy} == 3'b110, "R8 controls hold", 32'({sw_main, clk_off, busy}), 3'b110);
      stall_pg = 1'b0;
      cur_tag = "R8 retry up after abort";
      model_up(); request(1, 0, 1); wait_end(cur_tag);
    end

    // R8: fence never closes on power-down
    cur_tag = "R8 fence timeout";
    stall_fence = 1'b1;
    m_fence = 1; emit(); pulse_err();
    request(0, 1, 1); wait_end(cur_tag);
    stall_fence = 1'b0;
    cur_tag = "R8 retry down after abort";
    model_down(); request(0, 1, 1); wait_end(cur_tag);

    // R3: skip paths on the bare instance
    bare_latency(1'b1, "R3 bare up latency");
    chk({b_iso, b_rst_n, b_sram_pd, b_fence} == 7'b0_1_0000_0, "R3 bare up controls",
        32'({b_iso, b_rst_n, b_sram_pd, b_fence}), 7'b0100000);
    bare_latency(1'b0, "R7 bare down latency");
    chk({b_sw_main, b_sw_aux, b_clk_off} == 3'b001, "R6 bare down controls",
        32'({b_sw_main, b_sw_aux, b_clk_off}), 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule